// File: doc/BRIEF.md
# Transmit Low Power Idle Entry Controller

This block decides when the transmit path of an Ethernet MAC goes into, and comes out of, the Low Power Idle state used for energy-efficient operation. Software programs three registers. The control/status word holds four control bits: an enable, a copy of the PHY link status, an automate bit and an idle-timer enable. A second register sets how many ticks the transmitter must stay idle before it enters LPI. A third sets how many ticks the link-status bit must stay set before any entry is allowed. The controller watches the transmit queue empty flag, new-frame requests, FIFO flush pulses and a free-running tick.

There are two automatic modes. In the one-shot mode (idle-timer enable clear), LPI is entered once the queue has drained. On the first wake-up the hardware clears the enable bit, so software must re-arm the mode for every entry. In the idle-timed mode (idle-timer enable set), the enable stays set across wake-ups. Every idle period that lasts long enough enters LPI again.

The controller is a three-state machine with the states `LPI_OFF`, `LPI_ARMED` and `LPI_ACTIVE`:
- OFF→ARMED happens when enable and automate are both set.
- ARMED→ACTIVE happens on entry.
- ACTIVE→ARMED happens on a timed wake-up or on loss of link status.
- ACTIVE→OFF happens on a one-shot wake-up, or when enable or automate is cleared.
- ARMED→OFF happens when enable or automate is cleared.

Top module: `eee_txlpi_ctrl`

## Requirements
- R1: After reset, `lpi_req`, `lpi_active`, both event flags and every bit of `ctl_rdata` are 0.
- R2: Control bits sit in the control word at these positions: enable at bit 16, link status at bit 17, automate at bit 19 and idle-timer enable at bit 20. They read back at the same positions. The status bits read back as follows: entry flag at bit 0, exit flag at bit 1 and LPI active at bit 2.
- R3: While the enable bit is 0, `lpi_req` is 0. If enable is cleared while LPI is active, `lpi_req` falls in the same cycle as the enable bit reads 0, and `lpi_active` falls one cycle later.
- R4: One-shot entry, with a tick on every cycle, the queue empty and no frame request: `lpi_active` rises on rising edge max(H,1)+1 after the edge that writes the control word. H is the hold-off count.
- R5: In one-shot mode, a frame request, a non-empty queue or a FIFO flush ends LPI at the next edge. That edge also clears the enable bit, and no further entry follows.
- R6: Timed entry under the same stimulus as R4: `lpi_active` rises on rising edge max(H,I,1)+1 after the control write. I is the idle count.
- R7: In timed mode a wake-up ends LPI but leaves enable set. Once the queue is empty again, LPI is re-entered on edge I+1 after the wake-up edge.
- R8: With automate at 0, no LPI is requested, whatever the enable and idle-timer enable bits hold.
- R9: The hold-off and idle counters advance only on cycles with `tick` high. With no ticks and a nonzero hold-off, no entry takes place.
- R10: Clearing the link-status bit ends LPI and restarts the hold-off. After link status is set again, a timed-mode entry follows on edge H+1.
- R11: The entry flag is set when LPI starts and the exit flag is set when LPI ends. Both stay set until a `ctl_rd` strobe clears them.
- R12: `lpi_req` falls in the same cycle as a wake-up condition appears, before `lpi_active` falls. `lpi_req` is never high while `lpi_active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control word write data |
| ctl_rd | input | 1 | Read strobe; clears the event flags |
| ctl_rdata | output | 32 | Control/status word read data |
| idle_wr | input | 1 | Write strobe for the idle-count register |
| idle_wdata | input | IDLE_W | Idle ticks required before timed entry |
| hold_wr | input | 1 | Write strobe for the hold-off register |
| hold_wdata | input | HOLD_W | Ticks link status must stay set |
| txq_empty | input | 1 | Transmit queue has no pending frame |
| frame_req | input | 1 | A new frame is waiting to be sent |
| fifo_flush | input | 1 | Transmit FIFO flush pulse |
| tick | input | 1 | Time base strobe for both counters |
| lpi_req | output | 1 | Request to PHY-side logic to signal LPI |
| lpi_active | output | 1 | Transmit path is in LPI |
| evt_enter | output | 1 | Sticky LPI-entry event flag |
| evt_exit | output | 1 | Sticky LPI-exit event flag |

## Verification
The bench builds the block with 4-bit idle and hold-off counters. This makes every combination of hold-off 0..3 and idle 0..3 affordable to sweep. Each entry latency is checked against max(H,I,1)+1 for timed mode and max(H,1)+1 for one-shot mode. The bench drives the tick on every cycle, so these latencies are exact edge counts. A run with the tick held low confirms that entry depends on the tick. The small widths also keep the re-entry and hold-off restart cases down to a few cycles each.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
    typedef enum logic [1:0] {
        LPI_OFF    = 2'd0,
        LPI_ARMED  = 2'd1,
        LPI_ACTIVE = 2'd2
    } lpi_state_t;

    localparam int CTL_EN_BIT   = 16;
    localparam int CTL_PLS_BIT  = 17;
    localparam int CTL_AUTO_BIT = 19;
    localparam int CTL_TMR_BIT  = 20;
    localparam int ST_ENTER_BIT = 0;
    localparam int ST_EXIT_BIT  = 1;
    localparam int ST_ACT_BIT   = 2;
endpackage

// File: rtl/eee_lpi_csr.sv
module eee_lpi_csr
    import eee_lpi_pkg::*;
#(
    parameter int IDLE_W = 16,
    parameter int HOLD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    input  logic              ctl_rd,
    input  logic              idle_wr,
    input  logic [IDLE_W-1:0] idle_wdata,
    input  logic              hold_wr,
    input  logic [HOLD_W-1:0] hold_wdata,
    input  logic              hw_clr_en,
    input  logic              ev_enter,
    input  logic              ev_exit,
    input  logic              lpi_active,
    output logic              en_q,
    output logic              pls_q,
    output logic              auto_q,
    output logic              tmr_q,
    output logic [IDLE_W-1:0] idle_lim,
    output logic [HOLD_W-1:0] hold_lim,
    output logic              flag_enter,
    output logic              flag_exit,
    output logic [31:0]       rdata
);
    // Enable bit: a software write takes precedence over the hardware clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (ctl_wr) begin
            en_q <= ctl_wdata[CTL_EN_BIT];
        end else if (hw_clr_en) begin
            en_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pls_q  <= 1'b0;
            auto_q <= 1'b0;
            tmr_q  <= 1'b0;
        end else if (ctl_wr) begin
            pls_q  <= ctl_wdata[CTL_PLS_BIT];
            auto_q <= ctl_wdata[CTL_AUTO_BIT];
            tmr_q  <= ctl_wdata[CTL_TMR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_lim <= '0;
            hold_lim <= '0;
        end else begin
            if (idle_wr) idle_lim <= idle_wdata;
            if (hold_wr) hold_lim <= hold_wdata;
        end
    end

    // Sticky flags: a new event beats a clearing read in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_enter <= 1'b0;
            flag_exit  <= 1'b0;
        end else begin
            if (ev_enter)    flag_enter <= 1'b1;
            else if (ctl_rd) flag_enter <= 1'b0;
            if (ev_exit)     flag_exit  <= 1'b1;
            else if (ctl_rd) flag_exit  <= 1'b0;
        end
    end

    always_comb begin
        rdata               = '0;
        rdata[CTL_EN_BIT]   = en_q;
        rdata[CTL_PLS_BIT]  = pls_q;
        rdata[CTL_AUTO_BIT] = auto_q;
        rdata[CTL_TMR_BIT]  = tmr_q;
        rdata[ST_ENTER_BIT] = flag_enter;
        rdata[ST_EXIT_BIT]  = flag_exit;
        rdata[ST_ACT_BIT]   = lpi_active;
    end
endmodule

// File: rtl/eee_lpi_tickcnt.sv
// Saturating tick counter: restarts while 'restart' is high, and reports
// 'done' once it has reached the programmed limit.
module eee_lpi_tickcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = !restart && (cnt_q >= limit);
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
    import eee_lpi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic auto_en,
    input  logic tmr_en,
    input  logic link_ok,
    input  logic idle_done,
    input  logic txq_empty,
    input  logic frame_req,
    input  logic fifo_flush,
    output logic wake,
    output logic lpi_req,
    output logic lpi_active,
    output logic go_enter,
    output logic go_exit,
    output logic clr_en
);
    lpi_state_t state_q, state_d;
    logic armed;
    logic quiet;
    logic entry_ok;

    assign armed    = en && auto_en;
    assign quiet    = txq_empty && !frame_req && !fifo_flush;
    assign wake     = !quiet;
    assign entry_ok = tmr_en ? (idle_done && quiet) : quiet;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LPI_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        clr_en  = 1'b0;
        unique case (state_q)
            LPI_OFF: begin
                if (armed) state_d = LPI_ARMED;
            end
            LPI_ARMED: begin
                if (!armed)                    state_d = LPI_OFF;
                else if (link_ok && entry_ok)  state_d = LPI_ACTIVE;
            end
            LPI_ACTIVE: begin
                if (!armed) begin
                    state_d = LPI_OFF;
                end else if (!link_ok) begin
                    state_d = LPI_ARMED;
                end else if (wake) begin
                    if (tmr_en) begin
                        state_d = LPI_ARMED;
                    end else begin
                        state_d = LPI_OFF;
                        clr_en  = 1'b1;
                    end
                end
            end
            default: state_d = LPI_OFF;
        endcase
    end

    always_comb begin
        lpi_active = (state_q == LPI_ACTIVE);
        lpi_req    = (state_q == LPI_ACTIVE) && (state_d == LPI_ACTIVE);
        go_enter   = (state_q != LPI_ACTIVE) && (state_d == LPI_ACTIVE);
        go_exit    = (state_q == LPI_ACTIVE) && (state_d != LPI_ACTIVE);
    end
endmodule

// File: rtl/eee_txlpi_ctrl.sv
module eee_txlpi_ctrl #(
    parameter int IDLE_W = 16,
    parameter int HOLD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [31:0]       ctl_wdata,
    input  logic              ctl_rd,
    output logic [31:0]       ctl_rdata,
    input  logic              idle_wr,
    input  logic [IDLE_W-1:0] idle_wdata,
    input  logic              hold_wr,
    input  logic [HOLD_W-1:0] hold_wdata,
    input  logic              txq_empty,
    input  logic              frame_req,
    input  logic              fifo_flush,
    input  logic              tick,
    output logic              lpi_req,
    output logic              lpi_active,
    output logic              evt_enter,
    output logic              evt_exit
);
    logic              en_q, pls_q, auto_q, tmr_q;
    logic [IDLE_W-1:0] idle_lim;
    logic [HOLD_W-1:0] hold_lim;
    logic              link_ok, idle_done;
    logic              go_enter, go_exit, clr_en, wake;
    logic              idle_restart;

    eee_lpi_csr #(.IDLE_W(IDLE_W), .HOLD_W(HOLD_W)) u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_wdata),
        .ctl_rd     (ctl_rd),
        .idle_wr    (idle_wr),
        .idle_wdata (idle_wdata),
        .hold_wr    (hold_wr),
        .hold_wdata (hold_wdata),
        .hw_clr_en  (clr_en),
        .ev_enter   (go_enter),
        .ev_exit    (go_exit),
        .lpi_active (lpi_active),
        .en_q       (en_q),
        .pls_q      (pls_q),
        .auto_q     (auto_q),
        .tmr_q      (tmr_q),
        .idle_lim   (idle_lim),
        .hold_lim   (hold_lim),
        .flag_enter (evt_enter),
        .flag_exit  (evt_exit),
        .rdata      (ctl_rdata)
    );

    // Link-status hold-off: runs while the link-status bit is set.
    eee_lpi_tickcnt #(.W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!pls_q),
        .tick    (tick),
        .limit   (hold_lim),
        .done    (link_ok)
    );

    // Idle timer: runs only in timed mode and restarts on any activity.
    assign idle_restart = !(en_q && auto_q && tmr_q) || wake;

    eee_lpi_tickcnt #(.W(IDLE_W)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (idle_restart),
        .tick    (tick),
        .limit   (idle_lim),
        .done    (idle_done)
    );

    eee_lpi_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en_q),
        .auto_en    (auto_q),
        .tmr_en     (tmr_q),
        .link_ok    (link_ok),
        .idle_done  (idle_done),
        .txq_empty  (txq_empty),
        .frame_req  (frame_req),
        .fifo_flush (fifo_flush),
        .wake       (wake),
        .lpi_req    (lpi_req),
        .lpi_active (lpi_active),
        .go_enter   (go_enter),
        .go_exit    (go_exit),
        .clr_en     (clr_en)
    );
endmodule

// File: rtl/eee_txlpi_checker.sv
module eee_txlpi_checker (
    input logic clk,
    input logic rst_n,
    input logic en_q,
    input logic pls_q,
    input logic auto_q,
    input logic tmr_q,
    input logic link_ok,
    input logic wake,
    input logic ctl_wr,
    input logic lpi_req,
    input logic lpi_active,
    input logic evt_enter,
    input logic evt_exit
);
    assert_no_req_when_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !lpi_req);

    assert_no_req_without_auto_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_q |-> !lpi_req);

    assert_oneshot_clears_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_active && wake && en_q && auto_q && link_ok && !tmr_q && !ctl_wr) |=> !en_q);

    assert_timed_keeps_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_active && wake && en_q && auto_q && tmr_q && !ctl_wr) |=> en_q);

    assert_link_loss_exits_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lpi_active && !pls_q) |=> !lpi_active);

    assert_enter_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpi_active) |-> evt_enter);

    assert_exit_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpi_active) |-> evt_exit);

    assert_req_within_active_R12: assert property (@(posedge clk) disable iff (!rst_n)
        lpi_req |-> lpi_active);
endmodule

bind eee_txlpi_ctrl eee_txlpi_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_q       (en_q),
    .pls_q      (pls_q),
    .auto_q     (auto_q),
    .tmr_q      (tmr_q),
    .link_ok    (link_ok),
    .wake       (wake),
    .ctl_wr     (ctl_wr),
    .lpi_req    (lpi_req),
    .lpi_active (lpi_active),
    .evt_enter  (evt_enter),
    .evt_exit   (evt_exit)
);

// File: tb/eee_txlpi_ctrl_bench.sv
module eee_txlpi_ctrl_bench;
    localparam int IW = 4;
    localparam int HW = 4;
    localparam logic [31:0] B_EN   = 32'h1 << 16;
    localparam logic [31:0] B_PLS  = 32'h1 << 17;
    localparam logic [31:0] B_AUTO = 32'h1 << 19;
    localparam logic [31:0] B_TMR  = 32'h1 << 20;
    localparam logic [31:0] ONESHOT = B_EN | B_PLS | B_AUTO;
    localparam logic [31:0] TIMED   = B_EN | B_PLS | B_AUTO | B_TMR;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0, ctl_rd = 1'b0, idle_wr = 1'b0, hold_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;
    logic [IW-1:0] idle_wdata = '0;
    logic [HW-1:0] hold_wdata = '0;
    logic txq_empty = 1'b1, frame_req = 1'b0, fifo_flush = 1'b0, tick = 1'b1;
    logic lpi_req, lpi_active, evt_enter, evt_exit;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    eee_txlpi_ctrl #(.IDLE_W(IW), .HOLD_W(HW)) u_eee_txlpi_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata),
        .idle_wr(idle_wr), .idle_wdata(idle_wdata), .hold_wr(hold_wr), .hold_wdata(hold_wdata),
        .txq_empty(txq_empty), .frame_req(frame_req), .fifo_flush(fifo_flush), .tick(tick),
        .lpi_req(lpi_req), .lpi_active(lpi_active), .evt_enter(evt_enter), .evt_exit(evt_exit)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [31:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(posedge clk); #1;
        ctl_wr = 1'b0;
    endtask

    task automatic set_lims(input int h, input int i);
        @(negedge clk);
        hold_wr = 1'b1; hold_wdata = HW'(h);
        idle_wr = 1'b1; idle_wdata = IW'(i);
        @(posedge clk); #1;
        hold_wr = 1'b0; idle_wr = 1'b0;
    endtask

    task automatic rd_clear;
        @(negedge clk);
        ctl_rd = 1'b1;
        @(posedge clk); #1;
        ctl_rd = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
        end
    endtask

    // Counts rising edges until lpi_active is seen; 0 if it never rises.
    task automatic edges_to_entry(input int lim, output int got);
        got = 0;
        for (int j = 1; j <= lim; j++) begin
            @(posedge clk); #1;
            if (lpi_active && got == 0) begin
                got = j;
                break;
            end
        end
    endtask

    task automatic quiesce;
        wr_ctl(32'h0);
        idle_cycles(2);
        rd_clear();
    endtask

    function automatic int max3(input int a, input int b, input int c);
        int m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    initial begin
        int got;
        idle_cycles(2);
        #1 rst_n = 1'b1;
        idle_cycles(1);

        // R1 reset state
        check("R1 lpi_req", {31'b0, lpi_req}, 32'h0);
        check("R1 lpi_active", {31'b0, lpi_active}, 32'h0);
        check("R1 flags", {30'b0, evt_enter, evt_exit}, 32'h0);
        check("R1 rdata", ctl_rdata, 32'h0);

        // R2 field positions
        wr_ctl(TIMED);
        check("R2 control readback", ctl_rdata & 32'h001B_0000, TIMED);
        quiesce();

        // R8 automate=0: no entry with enable and timer enable set
        set_lims(0, 0);
        wr_ctl(B_EN | B_PLS | B_TMR);
        edges_to_entry(20, got);
        check("R8 no entry without automate", got, 0);
        check("R8 lpi_req low", {31'b0, lpi_req}, 32'h0);
        quiesce();

        // R6 timed-mode entry sweep
        for (int h = 0; h < 4; h++) begin
            for (int i = 0; i < 4; i++) begin
                set_lims(h, i);
                wr_ctl(TIMED);
                edges_to_entry(20, got);
                check($sformatf("R6 timed entry h=%0d i=%0d", h, i), got, max3(h, i, 1) + 1);
                quiesce();
            end
        end

        // R4 one-shot entry sweep (idle count irrelevant)
        for (int h = 0; h < 4; h++) begin
            set_lims(h, 3);
            wr_ctl(ONESHOT);
            edges_to_entry(20, got);
            check($sformatf("R4 oneshot entry h=%0d", h), got, max3(h, 1, 1) + 1);
            quiesce();
        end

        // R5/R12/R11 one-shot exit on frame request
        set_lims(1, 0);
        wr_ctl(ONESHOT);
        edges_to_entry(20, got);
        check("R11 entry flag", {31'b0, evt_enter}, 32'h1);
        check("R2 status active bit", ctl_rdata[2], 1'b1);
        @(negedge clk);
        frame_req = 1'b1;
        #1;
        check("R12 req drops on wake", {31'b0, lpi_req}, 32'h0);
        check("R12 active still high", {31'b0, lpi_active}, 32'h1);
        @(posedge clk); #1;
        frame_req = 1'b0;
        check("R5 exit on frame request", {31'b0, lpi_active}, 32'h0);
        check("R5 enable cleared", ctl_rdata[16], 1'b0);
        check("R11 exit flag", {31'b0, evt_exit}, 32'h1);
        edges_to_entry(15, got);
        check("R5 no re-entry", got, 0);
        rd_clear();
        check("R11 flags cleared by read", {30'b0, evt_enter, evt_exit}, 32'h0);
        quiesce();

        // R5 one-shot exit on FIFO flush
        set_lims(0, 0);
        wr_ctl(ONESHOT);
        edges_to_entry(20, got);
        @(negedge clk);
        fifo_flush = 1'b1;
        @(posedge clk); #1;
        fifo_flush = 1'b0;
        check("R5 exit on flush", {31'b0, lpi_active}, 32'h0);
        check("R5 flush clears enable", ctl_rdata[16], 1'b0);
        quiesce();

        // R7 timed wake keeps enable and re-enters after I+1 edges
        set_lims(1, 3);
        wr_ctl(TIMED);
        edges_to_entry(20, got);
        @(negedge clk);
        txq_empty = 1'b0;
        @(posedge clk); #1;
        txq_empty = 1'b1;
        check("R7 exit on activity", {31'b0, lpi_active}, 32'h0);
        check("R7 enable kept", ctl_rdata[16], 1'b1);
        edges_to_entry(20, got);
        check("R7 re-entry edges", got, 4);

        // R10 link-status drop exits, hold-off restarts
        set_lims(2, 3);
        wr_ctl(B_EN | B_AUTO | B_TMR);
        check("R10 req drops with link status", {31'b0, lpi_req}, 32'h0);
        @(posedge clk); #1;
        check("R10 exit on link loss", {31'b0, lpi_active}, 32'h0);
        idle_cycles(3);
        check("R10 stays out without link", {31'b0, lpi_active}, 32'h0);
        wr_ctl(TIMED);
        edges_to_entry(20, got);
        check("R10 hold-off restarted", got, 3);

        // R3 clearing enable while active
        wr_ctl(B_PLS | B_AUTO | B_TMR);
        check("R3 req drops with enable", {31'b0, lpi_req}, 32'h0);
        check("R3 active one more cycle", {31'b0, lpi_active}, 32'h1);
        @(posedge clk); #1;
        check("R3 active falls", {31'b0, lpi_active}, 32'h0);
        quiesce();

        // R9 no ticks: no entry; ticks resume: entry after H+1 edges
        set_lims(2, 0);
        @(negedge clk);
        tick = 1'b0;
        wr_ctl(TIMED);
        edges_to_entry(20, got);
        check("R9 no entry without ticks", got, 0);
        @(negedge clk);
        tick = 1'b1;
        edges_to_entry(20, got);
        check("R9 entry once ticks resume", got, 3);
        quiesce();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule